// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block evaluates one of sixteen data-processing operations on a first register operand and a pre-shifted second operand. It returns the result word, the next negative, zero, carry and overflow flags, a write-enable for the destination register, and a signal that tells the surrounding core to reload the whole status word from its saved copy rather than take the new flags. The shifter, register file and instruction sequencing sit outside. The block receives the shifter's carry-out and the current flags as inputs.

The arithmetic group uses one shared adder. Reverse and with-carry forms are built by swapping the operands, inverting the second addend and picking the carry-in. The logical group takes its carry from the shifter and leaves overflow as it was. All outputs are registered once, so each operation presented with `valid_i` high appears on the outputs one clock later.

Top module: `alu_dp_core`

## Requirements
- R1: The 4-bit `op_i` selects the operation. The codes are 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC and 15 MVN. The logical codes produce rn&op2, rn^op2, rn|op2, op2, rn&~op2 and ~op2. TST uses the AND result and TEQ uses the EOR result.
- R2: The arithmetic codes produce the following results, all modulo 2^32. SUB and CMP give rn−op2. RSB gives op2−rn. ADD and CMN give rn+op2. ADC gives rn+op2+C. SBC gives rn−(op2+!C). RSC gives op2−(rn+!C). C is `flags_i[1]`.
- R3: The flag bus is ordered [3]=N, [2]=Z, [1]=C, [0]=V. For a flag-setting logical operation, N is result bit 31 and Z is set when the result is zero. C equals `shc_i` and V keeps `flags_i[0]`.
- R4: For a flag-setting addition (ADD, ADC, CMN), C is the unsigned carry out of bit 31 and V is set on signed overflow.
- R5: For a flag-setting subtraction (SUB, RSB, SBC, RSC, CMP), C is 1 when no borrow occurs and V is set on signed overflow of the subtraction.
- R6: The test codes 8 to 11 never assert `wr_en_o`. They update the flags whatever the value of `s_i`.
- R7: When `s_i` is 0 and the code is not a test code, `flags_o` equals `flags_i`.
- R8: `restore_o` is asserted exactly when the operation is valid, flag-setting, `dest_pc_i` is 1 and `has_saved_i` is 1. In that case `flags_o` equals `flags_i`. With `has_saved_i` at 0, a flag-setting write to the program counter updates the flags normally.
- R9: Outputs appear one clock after the inputs. `valid_o` follows `valid_i`, and `wr_en_o` and `restore_o` are 0 whenever `valid_o` is 0. Reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (instruction bits 24:21) |
| s_i | input | 1 | Set-flags request (instruction bit 20) |
| rn_i | input | DATA_W | First register operand |
| op2_i | input | DATA_W | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current N, Z, C, V |
| dest_pc_i | input | 1 | Destination is the program counter |
| has_saved_i | input | 1 | Current mode owns a saved status word |
| valid_o | output | 1 | Registered valid |
| result_o | output | DATA_W | Operation result |
| flags_o | output | 4 | Next N, Z, C, V |
| wr_en_o | output | 1 | Write result to destination |
| restore_o | output | 1 | Reload status word from saved copy |

## Verification
Every result, flag and control output is due exactly one rising edge after its inputs. The bench drives each operation on a falling edge and compares all outputs at the next falling edge against a behavioural model. That model works in 64-bit integer arithmetic to get carries and signed range. When `valid_i` is low, only the valid, write-enable and restore outputs are compared. Directed cases cover the carry and overflow edges, the borrow forms, test codes with the set-flags bit clear, and both outcomes of a flag-setting write to the program counter. Random operations then follow.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;

  typedef enum logic [2:0] {LG_AND, LG_EOR, LG_ORR, LG_MOV, LG_BIC, LG_MVN} logic_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    logic      is_logic;
    logic      is_test;
    logic      swap;
    logic      inv_b;
    cin_sel_e  cin;
    logic_fn_e lfn;
  } dec_t;

endpackage

// File: rtl/alu_dp_decode.sv
module alu_dp_decode
  import alu_dp_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o          = '0;
    dec_o.cin      = CIN_ZERO;
    dec_o.lfn      = LG_AND;
    dec_o.is_test  = (op_i[3:2] == 2'b10);
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: begin dec_o.is_logic = 1'b1; dec_o.lfn = LG_AND; end
      OP_EOR, OP_TEQ: begin dec_o.is_logic = 1'b1; dec_o.lfn = LG_EOR; end
      OP_ORR:         begin dec_o.is_logic = 1'b1; dec_o.lfn = LG_ORR; end
      OP_MOV:         begin dec_o.is_logic = 1'b1; dec_o.lfn = LG_MOV; end
      OP_BIC:         begin dec_o.is_logic = 1'b1; dec_o.lfn = LG_BIC; end
      OP_MVN:         begin dec_o.is_logic = 1'b1; dec_o.lfn = LG_MVN; end
      OP_SUB, OP_CMP: begin dec_o.inv_b = 1'b1; dec_o.cin = CIN_ONE; end
      OP_RSB:         begin dec_o.swap = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin = CIN_ONE; end
      OP_ADD, OP_CMN: begin dec_o.cin = CIN_ZERO; end
      OP_ADC:         begin dec_o.cin = CIN_FLAG; end
      OP_SBC:         begin dec_o.inv_b = 1'b1; dec_o.cin = CIN_FLAG; end
      OP_RSC:         begin dec_o.swap = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin = CIN_FLAG; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_dp_adder.sv
module alu_dp_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[DATA_W];
  // same-sign addends, different-sign sum
  assign ovf_o  = (a_i[MSB] == b_i[MSB]) && (full[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
  import alu_dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      LG_AND:  res_o = rn_i & op2_i;
      LG_EOR:  res_o = rn_i ^ op2_i;
      LG_ORR:  res_o = rn_i | op2_i;
      LG_MOV:  res_o = op2_i;
      LG_BIC:  res_o = rn_i & ~op2_i;
      LG_MVN:  res_o = ~op2_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core
  import alu_dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              s_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic              shc_i,
  input  logic [3:0]        flags_i,
  input  logic              dest_pc_i,
  input  logic              has_saved_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              wr_en_o,
  output logic              restore_o
);

  localparam int MSB = DATA_W - 1;

  dec_t              dec;
  nzcv_t             fl_in, fl_nxt;
  logic [DATA_W-1:0] add_a, add_b, b_pre, sum, lres, res_c;
  logic              cin, cout, ovf, eff_s, restore_c, wr_c;

  assign fl_in = nzcv_t'(flags_i);

  alu_dp_decode u_dec (.op_i(op_i), .dec_o(dec));

  // operand routing for reverse and borrow forms
  assign add_a = dec.swap ? op2_i : rn_i;
  assign b_pre = dec.swap ? rn_i  : op2_i;
  assign add_b = dec.inv_b ? ~b_pre : b_pre;

  always_comb begin
    unique case (dec.cin)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = fl_in.c;
      default:  cin = 1'b0;
    endcase
  end

  alu_dp_adder #(.DATA_W(DATA_W)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  alu_dp_logic #(.DATA_W(DATA_W)) u_lgc (
    .rn_i(rn_i), .op2_i(op2_i), .fn_i(dec.lfn), .res_o(lres)
  );

  assign res_c     = dec.is_logic ? lres : sum;
  assign eff_s     = s_i | dec.is_test;
  assign restore_c = valid_i & eff_s & dest_pc_i & has_saved_i;
  assign wr_c      = valid_i & ~dec.is_test;

  always_comb begin
    if (!eff_s || restore_c) begin
      fl_nxt = fl_in;
    end else begin
      fl_nxt.n = res_c[MSB];
      fl_nxt.z = (res_c == '0);
      fl_nxt.c = dec.is_logic ? shc_i    : cout;
      fl_nxt.v = dec.is_logic ? fl_in.v  : ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
      wr_en_o   <= 1'b0;
      restore_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      result_o  <= res_c;
      flags_o   <= fl_nxt;
      wr_en_o   <= wr_c;
      restore_o <= restore_c;
    end
  end

  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ($past(op_i[3:2]) == 2'b10) |-> !wr_en_o); // R6

  AST_PASS_NO_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !$past(s_i) && ($past(op_i[3:2]) != 2'b10) |-> flags_o == $past(flags_i)); // R7

  AST_RESTORE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> valid_o && flags_o == $past(flags_i)); // R8

  AST_LOGIC_V_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(dec.is_logic) |-> flags_o[0] == $past(flags_i[0])); // R3

  AST_NZ_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !restore_o && ($past(s_i) || $past(op_i[3:2]) == 2'b10)
    |-> flags_o[3] == result_o[MSB] && flags_o[2] == (result_o == '0)); // R3

  AST_WR_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o); // R9

endmodule

// File: tb/alu_dp_core_tb_top.sv
module alu_dp_core_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        s_i = 1'b0;
  logic [31:0] rn_i = '0;
  logic [31:0] op2_i = '0;
  logic        shc_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        dest_pc_i = 1'b0;
  logic        has_saved_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;
  logic        wr_en_o;
  logic        restore_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  alu_dp_core #(.DATA_W(32)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .s_i(s_i),
    .rn_i(rn_i), .op2_i(op2_i), .shc_i(shc_i), .flags_i(flags_i),
    .dest_pc_i(dest_pc_i), .has_saved_i(has_saved_i), .valid_o(valid_o),
    .result_o(result_o), .flags_o(flags_o), .wr_en_o(wr_en_o), .restore_o(restore_o)
  );

  function automatic void ref_model(
    input logic [3:0] op, input logic s, input logic [31:0] a, input logic [31:0] b,
    input logic shc, input logic [3:0] fl, input logic pc, input logic sv, input logic v,
    output logic [31:0] r, output logic [3:0] f, output logic w, output logic rs);
    longint ua, ub, sa, sb, ss, us;
    longint hi, lo;
    logic cf, test, es, cy, ov, lgc;
    ua = {32'b0, a}; ub = {32'b0, b};
    sa = longint'($signed(a)); sb = longint'($signed(b));
    hi = 64'sd2147483647; lo = -64'sd2147483648;
    cf = fl[1]; test = (op >= 4'd8 && op <= 4'd11); es = s | test;
    cy = 1'b0; ov = 1'b0; lgc = 1'b0; ss = 0; r = '0;
    case (op)
      4'd0, 4'd8:  begin r = a & b;  lgc = 1'b1; end
      4'd1, 4'd9:  begin r = a ^ b;  lgc = 1'b1; end
      4'd12:       begin r = a | b;  lgc = 1'b1; end
      4'd13:       begin r = b;      lgc = 1'b1; end
      4'd14:       begin r = a & ~b; lgc = 1'b1; end
      4'd15:       begin r = ~b;     lgc = 1'b1; end
      4'd4, 4'd11: begin us = ua + ub; cy = us[32]; ss = sa + sb; end
      4'd5:        begin us = ua + ub + longint'(cf); cy = us[32]; ss = sa + sb + longint'(cf); end
      4'd2, 4'd10: begin cy = (ua >= ub); ss = sa - sb; end
      4'd3:        begin cy = (ub >= ua); ss = sb - sa; end
      4'd6:        begin cy = (ua >= ub + longint'(!cf)); ss = sa - sb - longint'(!cf); end
      default:     begin cy = (ub >= ua + longint'(!cf)); ss = sb - sa - longint'(!cf); end
    endcase
    if (lgc) begin
      cy = shc; ov = fl[0];
    end else begin
      r  = ss[31:0];
      ov = (ss > hi) || (ss < lo);
    end
    rs = v && es && pc && sv;
    w  = v && !test;
    if (!es || rs) f = fl;
    else           f = {r[31], (r == 32'd0), cy, ov};
  endfunction

  task automatic step(input logic [3:0] op, input logic s, input logic [31:0] a,
                      input logic [31:0] b, input logic shc, input logic [3:0] fl,
                      input logic pc, input logic sv, input logic v, input string tag);
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ew, ers;
    op_i = op; s_i = s; rn_i = a; op2_i = b; shc_i = shc; flags_i = fl;
    dest_pc_i = pc; has_saved_i = sv; valid_i = v;
    ref_model(op, s, a, b, shc, fl, pc, sv, v, er, ef, ew, ers);
    @(negedge clk_i);
    checks++;
    if (v) begin
      if (valid_o !== 1'b1 || result_o !== er || flags_o !== ef || wr_en_o !== ew || restore_o !== ers) begin
        errors++;
        $display("FAIL %s op=%0d: got v=%b r=%h f=%b w=%b rs=%b exp v=1 r=%h f=%b w=%b rs=%b",
                 tag, op, valid_o, result_o, flags_o, wr_en_o, restore_o, er, ef, ew, ers);
      end
    end else begin
      if (valid_o !== 1'b0 || wr_en_o !== 1'b0 || restore_o !== 1'b0) begin
        errors++;
        $display("FAIL %s idle: got v=%b w=%b rs=%b exp 0 0 0", tag, valid_o, wr_en_o, restore_o);
      end
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    if (op >= 4'd8 && op <= 4'd11) return "R6";
    if (op == 4'd0 || op == 4'd1 || op >= 4'd12) return "R3";
    if (op == 4'd4 || op == 4'd5) return "R4";
    return "R5";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++; // R9 reset state
    if (valid_o !== 1'b0 || result_o !== 32'd0 || flags_o !== 4'd0 || wr_en_o !== 1'b0 || restore_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: got v=%b r=%h f=%b w=%b rs=%b exp all zero",
               valid_o, result_o, flags_o, wr_en_o, restore_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 logical results
    step(4'd0,  1'b0, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R1");
    step(4'd1,  1'b0, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 4'b1010, 1'b0, 1'b0, 1'b1, "R1");
    step(4'd12, 1'b0, 32'h0000_00F0, 32'h0F00_0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R1");
    step(4'd13, 1'b0, 32'h1111_1111, 32'hDEAD_BEEF, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R1");
    step(4'd14, 1'b0, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R1");
    step(4'd15, 1'b0, 32'h0,         32'h0000_0001, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R1");
    // R2 arithmetic with carry-in forms
    step(4'd5,  1'b0, 32'd10, 32'd20, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1, "R2");
    step(4'd6,  1'b0, 32'd10, 32'd3,  1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R2");
    step(4'd7,  1'b0, 32'd3,  32'd10, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R2");
    step(4'd3,  1'b0, 32'd7,  32'd5,  1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R2");
    // R3 logical flags: C from shifter, V kept
    step(4'd13, 1'b1, 32'd0, 32'h8000_0000, 1'b1, 4'b0001, 1'b0, 1'b0, 1'b1, "R3");
    step(4'd0,  1'b1, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 4'b0011, 1'b0, 1'b0, 1'b1, "R3");
    // R4 addition edges
    step(4'd4,  1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R4");
    step(4'd4,  1'b1, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R4");
    step(4'd5,  1'b1, 32'hFFFF_FFFF, 32'd0, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1, "R4");
    // R5 subtraction edges
    step(4'd2,  1'b1, 32'd5, 32'd5, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R5");
    step(4'd2,  1'b1, 32'd0, 32'd1, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1, "R5");
    step(4'd2,  1'b1, 32'h8000_0000, 32'd1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R5");
    step(4'd6,  1'b1, 32'd5, 32'd5, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R5");
    step(4'd7,  1'b1, 32'd5, 32'd5, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1, "R5");
    // R6 test codes with S clear
    step(4'd10, 1'b0, 32'd3, 32'd9, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R6");
    step(4'd8,  1'b0, 32'hFF, 32'h100, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, "R6");
    step(4'd11, 1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R6");
    step(4'd9,  1'b0, 32'h1234, 32'h1234, 1'b0, 4'b1001, 1'b0, 1'b0, 1'b1, "R6");
    // R7 S clear passes flags
    step(4'd2,  1'b0, 32'd0, 32'd1, 1'b1, 4'b0110, 1'b0, 1'b0, 1'b1, "R7");
    step(4'd13, 1'b0, 32'd0, 32'd0, 1'b1, 4'b1001, 1'b0, 1'b0, 1'b1, "R7");
    // R8 restore and its absence
    step(4'd2,  1'b1, 32'd0, 32'd1, 1'b0, 4'b0101, 1'b1, 1'b1, 1'b1, "R8");
    step(4'd2,  1'b1, 32'd0, 32'd1, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b1, "R8");
    step(4'd13, 1'b0, 32'd0, 32'd4, 1'b0, 4'b0101, 1'b1, 1'b1, 1'b1, "R8");
    step(4'd10, 1'b0, 32'd1, 32'd1, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, "R8");
    // R9 idle cycle
    step(4'd4,  1'b1, 32'd1, 32'd1, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, "R9");
    step(4'd4,  1'b1, 32'd1, 32'd2, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = $urandom;
      b  = $urandom;
      if ((i % 7) == 0) a = {a[31], 31'h7FFF_FFFF};
      if ((i % 11) == 0) b = a;
      step(op, 1'($urandom), a, b, 1'($urandom), 4'($urandom),
           ((i % 5) == 0), 1'($urandom), ((i % 13) != 0),
           ((i % 13) == 0) ? "R9" : tag_of(op));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule